// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block arbitrates lock-free synchronization for several processors that share one small word memory. Every processor may hold a single reservation, made of a valid bit and a word address. A load-reserved request returns the addressed word and records the reservation. A later store-conditional to the same address writes memory only if the reservation is still intact, and it reports pass or fail back to the requester. Software builds atomic read-modify-write sequences on top of this: it retries whenever the conditional store reports a failure.

Requests arrive serialized, at most one per cycle, on a single request port that carries the processor number, an operation code, a word address and write data. Successful conditional stores and ordinary stores both kill every reservation that points at the written word. A conditional store always consumes the requester's own reservation, whether it passes or fails. Each request produces a registered response one cycle later. The memory update and the reservation changes take effect on the same clock edge.

Top module: `lrsc_tracker`

## Requirements
- R1: A load-reserved request (op code 1) from processor p sets p's reservation valid and records the request address. Its response carries the stored word at that address.
- R2: A store-conditional request (op code 3) passes only when the requester's reservation is valid and its recorded address equals the request address. rsp_status is 0 for pass and 1 for fail.
- R3: A passing store-conditional writes req_wdata into the addressed word.
- R4: A passing store-conditional invalidates every other processor's reservation on the same address. Reservations on other addresses are kept.
- R5: A failing store-conditional leaves memory unchanged and reports status 1.
- R6: Any store-conditional, whether it passes or fails, leaves the requester's own reservation invalid.
- R7: An ordinary store (op code 2) writes memory and invalidates all reservations on that address, including the storing processor's own.
- R8: A new load-reserved from p replaces p's earlier reservation, so a conditional store to the old address then fails.
- R9: Reset empties all reservations, clears every memory word to 0 and holds rsp_valid low.
- R10: Every request with req_valid high produces a response exactly one cycle later. The response carries rsp_valid=1, the requester's number in rsp_cpu and, in rsp_rdata, the word as it stood before the request. An ordinary load (op code 0) changes neither memory nor any reservation. rsp_status is 0 for every operation other than store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 load-reserved, 2 store, 3 store-conditional |
| req_cpu | input | CPU_W | Requesting processor number |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_cpu | output | CPU_W | Processor the response belongs to |
| rsp_rdata | output | DATA_W | Word value before the request |
| rsp_status | output | 1 | Conditional store result: 0 pass, 1 fail |

## Verification
The bench pairs directed cases with a few thousand random requests confined to four addresses and four processors, so that reservations collide often. The directed cases include two processors reserving the same word, where the winner must knock out the loser. A design that only cleared the writer's reservation would let the loser succeed as well. Other cases are a repeated conditional store after a pass, which a design that forgot R6 would wrongly accept, and an ordinary store to a word the storing processor reserved itself. A replaced reservation must not let a conditional store succeed at the old address, and after reset a conditional store with no prior reservation must fail. Every response is compared against a reference model kept in the bench, and later loads expose any memory write that a failing conditional store leaked.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_LR    = 2'd1,
        OP_STORE = 2'd2,
        OP_SC    = 2'd3
    } op_e;

endpackage

// File: rtl/lrsc_req_decode.sv
module lrsc_req_decode
    import lrsc_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       sc_hit,
    output logic       lr_en,
    output logic       mem_we,
    output logic       addr_clr_en,
    output logic       own_clr_en,
    output logic       sc_fail
);

    op_e op;
    logic st_en;
    logic sc_en;

    always_comb begin
        op          = op_e'(req_op);
        lr_en       = req_valid && (op == OP_LR);
        st_en       = req_valid && (op == OP_STORE);
        sc_en       = req_valid && (op == OP_SC);
        mem_we      = st_en || (sc_en && sc_hit);
        addr_clr_en = mem_we;
        own_clr_en  = sc_en;
        sc_fail     = sc_en && !sc_hit;
    end

endmodule

// File: rtl/lrsc_word_mem.sv
module lrsc_word_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] words;
    } mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d.words[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q.words[addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q.words[$past(addr)] == $past(wdata))); // R3

    AST_NO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q)); // R5

endmodule

// File: rtl/lrsc_resv_table.sv
module lrsc_resv_table #(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 4,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_en,
    input  logic              own_clr_en,
    input  logic              addr_clr_en,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              sc_hit
);

    typedef struct packed {
        logic [NCPU-1:0]             valid;
        logic [NCPU-1:0][ADDR_W-1:0] addr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [NCPU-1:0]             valid_nx;
    logic [NCPU-1:0][ADDR_W-1:0] addr_nx;
    logic [NCPU-1:0]             valid_q;
    logic [NCPU-1:0][ADDR_W-1:0] addr_q;

    assign valid_q = tbl_q.valid;
    assign addr_q  = tbl_q.addr;

    for (genvar i = 0; i < NCPU; i++) begin : g_entry
        logic mine;
        logic addr_match;

        always_comb begin
            mine       = (req_cpu == CPU_W'(i));
            addr_match = valid_q[i] && (addr_q[i] == req_addr);
            valid_nx[i] = valid_q[i];
            addr_nx[i]  = addr_q[i];
            if (lr_en && mine) begin
                valid_nx[i] = 1'b1;
                addr_nx[i]  = req_addr;
            end else if ((own_clr_en && mine) || (addr_clr_en && addr_match)) begin
                valid_nx[i] = 1'b0;
            end
        end

        AST_LR_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
            (lr_en && req_cpu == CPU_W'(i)) |=>
                (valid_q[i] && addr_q[i] == $past(req_addr))); // R1

        AST_SC_OWN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (own_clr_en && req_cpu == CPU_W'(i)) |=> !valid_q[i]); // R6

        AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_clr_en && valid_q[i] && addr_q[i] == req_addr) |=> !valid_q[i]); // R4

        AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (req_cpu != CPU_W'(i) && valid_q[i] && addr_q[i] != req_addr) |=>
                (valid_q[i] && $stable(addr_q[i]))); // R4
    end

    always_comb begin
        tbl_d.valid = valid_nx;
        tbl_d.addr  = addr_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign sc_hit = valid_q[req_cpu] && (addr_q[req_cpu] == req_addr);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0)); // R9

endmodule

// File: rtl/lrsc_tracker.sv
module lrsc_tracker
    import lrsc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [CPU_W-1:0]  rsp_cpu,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_status
);

    typedef struct packed {
        logic              valid;
        logic [CPU_W-1:0]  cpu;
        logic [DATA_W-1:0] rdata;
        logic              status;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic              sc_hit;
    logic              lr_en;
    logic              mem_we;
    logic              addr_clr_en;
    logic              own_clr_en;
    logic              sc_fail;
    logic [DATA_W-1:0] mem_rdata;

    lrsc_req_decode u_decode (
        .req_valid   (req_valid),
        .req_op      (req_op),
        .sc_hit      (sc_hit),
        .lr_en       (lr_en),
        .mem_we      (mem_we),
        .addr_clr_en (addr_clr_en),
        .own_clr_en  (own_clr_en),
        .sc_fail     (sc_fail)
    );

    lrsc_resv_table #(
        .NCPU   (NCPU),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .lr_en       (lr_en),
        .own_clr_en  (own_clr_en),
        .addr_clr_en (addr_clr_en),
        .req_cpu     (req_cpu),
        .req_addr    (req_addr),
        .sc_hit      (sc_hit)
    );

    lrsc_word_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = req_valid;
        if (req_valid) begin
            rsp_d.cpu    = req_cpu;
            rsp_d.rdata  = mem_rdata;
            rsp_d.status = sc_fail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_cpu    = rsp_q.cpu;
    assign rsp_rdata  = rsp_q.rdata;
    assign rsp_status = rsp_q.status;

    AST_SC_PASS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && sc_hit) |=> (rsp_valid && !rsp_status)); // R2

    AST_SC_FAIL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && !sc_hit) |=> (rsp_valid && rsp_status)); // R5

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && rsp_cpu == $past(req_cpu))); // R10

    AST_NON_SC_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'd3) |=> !rsp_status); // R10

endmodule

// File: tb/lrsc_tracker_tb.sv
module lrsc_tracker_tb;

    localparam int NCPU   = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int CPU_W  = 2;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [CPU_W-1:0]  req_cpu = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [CPU_W-1:0]  rsp_cpu;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_status;

    always #10 clk = ~clk;

    lrsc_tracker #(
        .NCPU   (NCPU),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_cpu    (req_cpu),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_cpu    (rsp_cpu),
        .rsp_rdata  (rsp_rdata),
        .rsp_status (rsp_status)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic              m_val  [NCPU];
    logic [ADDR_W-1:0] m_addr [NCPU];
    logic [DATA_W-1:0] m_mem  [DEPTH];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic sc_would_pass(input int c, input int a);
        return m_val[c] && (m_addr[c] == ADDR_W'(a));
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            3:       return "R2";
            2:       return "R7";
            1:       return "R1";
            default: return "R10";
        endcase
    endfunction

    // Issue one request, update the model, compare the response one cycle later.
    task automatic issue(input int c, input int op, input int a, input logic [DATA_W-1:0] d,
                         input string req);
        logic [DATA_W-1:0] exp_rd;
        logic              exp_st;
        logic              pass;
        exp_rd = m_mem[a];
        exp_st = 1'b0;
        case (op)
            1: begin
                m_val[c]  = 1'b1;
                m_addr[c] = ADDR_W'(a);
            end
            2: begin
                m_mem[a] = d;
                for (int i = 0; i < NCPU; i++)
                    if (m_val[i] && m_addr[i] == ADDR_W'(a)) m_val[i] = 1'b0;
            end
            3: begin
                pass   = sc_would_pass(c, a);
                exp_st = !pass;
                if (pass) begin
                    m_mem[a] = d;
                    for (int i = 0; i < NCPU; i++)
                        if (m_val[i] && m_addr[i] == ADDR_W'(a)) m_val[i] = 1'b0;
                end
                m_val[c] = 1'b0;
            end
            default: ;
        endcase
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_cpu   = CPU_W'(c);
        req_addr  = ADDR_W'(a);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " rsp_cpu"}, 64'(rsp_cpu), 64'(c));
        chk({req, " rsp_rdata"}, 64'(rsp_rdata), 64'(exp_rd));
        chk({req, " rsp_status"}, 64'(rsp_status), 64'(exp_st));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NCPU; i++) begin
            m_val[i]  = 1'b0;
            m_addr[i] = '0;
        end
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

        repeat (3) @(negedge clk);
        chk("R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);

        // R9: empty reservations and zero memory after reset
        for (int c = 0; c < NCPU; c++) issue(c, 3, c, 32'hDEAD_0000 + 32'(c), "R9 sc after reset");
        issue(0, 0, 5, 32'h0, "R9 load zero word");

        // R1/R2/R3: plain pass
        issue(0, 1, 2, 32'h0, "R1 lr");
        issue(0, 3, 2, 32'hA5A5_0001, "R2 sc pass");
        issue(1, 0, 2, 32'h0, "R3 written word visible");
        // R6: repeat after pass fails
        issue(0, 3, 2, 32'hBAD0_0001, "R6 repeat sc fails");
        // R6: failed sc also drops own reservation
        issue(1, 1, 3, 32'h0, "R1 lr cpu1");
        issue(1, 3, 4, 32'hBAD0_0002, "R5 sc wrong addr");
        issue(1, 3, 3, 32'hBAD0_0003, "R6 sc after fail");
        issue(2, 0, 3, 32'h0, "R5 memory untouched");

        // R4: two reservers on one word, a third elsewhere
        issue(0, 1, 7, 32'h0, "R1 lr cpu0");
        issue(1, 1, 7, 32'h0, "R1 lr cpu1");
        issue(2, 1, 8, 32'h0, "R1 lr cpu2");
        issue(1, 3, 7, 32'h1111_0007, "R4 winner sc");
        issue(0, 3, 7, 32'h2222_0007, "R4 loser sc fails");
        issue(2, 3, 8, 32'h3333_0008, "R4 other addr survives");

        // R7: ordinary store kills own and others' reservations
        issue(3, 1, 9, 32'h0, "R1 lr cpu3");
        issue(0, 1, 9, 32'h0, "R1 lr cpu0");
        issue(3, 2, 9, 32'h4444_0009, "R7 store");
        issue(3, 3, 9, 32'h5555_0009, "R7 own sc fails");
        issue(0, 3, 9, 32'h6666_0009, "R7 other sc fails");

        // R8: replacement
        issue(2, 1, 10, 32'h0, "R1 lr old");
        issue(2, 1, 11, 32'h0, "R8 lr new");
        issue(2, 3, 10, 32'h7777_000A, "R8 old addr fails");
        issue(2, 1, 10, 32'h0, "R1 lr again");
        issue(2, 1, 11, 32'h0, "R8 lr replace");
        issue(2, 3, 11, 32'h8888_000B, "R8 new addr passes");

        // R10: ordinary load leaves reservation intact
        issue(1, 1, 12, 32'h0, "R1 lr");
        issue(1, 0, 12, 32'h0, "R10 load");
        issue(1, 3, 12, 32'h9999_000C, "R10 sc after load passes");

        // Random mix on few addresses for heavy conflicts
        for (int k = 0; k < 3000; k++) begin
            int c;
            int op;
            int a;
            c  = int'($urandom_range(NCPU - 1, 0));
            op = int'($urandom_range(3, 0));
            a  = int'($urandom_range(3, 0));
            issue(c, op, a, $urandom, tag_of(op));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule